// File: doc/BRIEF.md
# Interrupt CPU Interface

This block is the per-processor side of an interrupt controller. A distributor hands it interrupt requests one at a time by ID. Each interrupt has a static priority and a group that come from configuration inputs. For every interrupt the block keeps a two-bit lifecycle state. It chooses the most urgent pending interrupt and drives the processor's FIQ or IRQ line.

The processor takes an interrupt by pulsing an acknowledge read. On the next cycle the block returns the ID of the interrupt being signalled, or a spurious ID if nothing qualifies, and marks that interrupt active. An end-of-interrupt write closes an interrupt. While an interrupt is active, the running priority it sets blocks any interrupt that is not strictly more urgent. A priority mask sets a second, global threshold.

Top module: `irq_cpu_iface`

## Requirements
- R1: After reset every interrupt state is inactive (code 00), both request lines are low and `ack_vld` is low.
- R2: A `set_vld` pulse for an in-range ID moves that interrupt from inactive (00) to pending (01), or from active (10) to active-and-pending (11). It leaves pending and active-and-pending unchanged. `int_state[2*i+:2]` holds interrupt i's state code.
- R3: An `ack_rd` pulse makes `ack_vld` high on the following cycle. If an interrupt is being signalled, `ack_id` carries its ID and that interrupt moves from pending to active in the same edge.
- R4: An `ack_rd` pulse while no interrupt is signalled returns `ack_id` = 1023 and changes no state.
- R5: An `eoi_vld` write moves the named interrupt from active to inactive, or from active-and-pending to pending. It has no effect on an interrupt in any other state.
- R6: Only interrupts in the pending state compete. The winner has the numerically lowest priority, and among equal priorities the lowest ID wins.
- R7: The winner is signalled only if its priority is numerically below `prio_mask`. If any interrupt is active or active-and-pending, the winner's priority must also be below the lowest priority among those.
- R8: A signalled group 0 interrupt (`cfg_grp` bit 0) drives `fiq_o` when `grp0_fiq` is 1 and `irq_o` when it is 0. A group 1 interrupt always drives `irq_o`. The two lines are never high together.
- R9: When an acknowledge or end-of-interrupt and a set hit the same interrupt in one cycle, the acknowledge or end-of-interrupt is applied first and the set after it. So ack plus set gives active-and-pending, and EOI plus set on an active interrupt gives pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| set_vld | input | 1 | Request pulse from the distributor |
| set_id | input | 10 | ID of the requested interrupt |
| cfg_prio | input | NUM_INT*PRIO_W | Priority of each interrupt, lower value more urgent |
| cfg_grp | input | NUM_INT | Group of each interrupt, 0 or 1 |
| grp0_fiq | input | 1 | Route group 0 to FIQ when 1, to IRQ when 0 |
| prio_mask | input | PRIO_W | Priority threshold |
| ack_rd | input | 1 | Acknowledge read strobe |
| ack_vld | output | 1 | Acknowledge result valid |
| ack_id | output | 10 | Acknowledged ID, or 1023 when spurious |
| eoi_vld | input | 1 | End-of-interrupt write strobe |
| eoi_id | input | 10 | ID being closed |
| irq_o | output | 1 | IRQ request line |
| fiq_o | output | 1 | FIQ request line |
| int_state | output | 2*NUM_INT | State code of every interrupt |

## Verification
A corrupted state code shows on `int_state` at the next sampling point. Within one acknowledge it also changes either the signalled line or the returned ID. A wrong running priority or a wrong arbitration result shows as a request line that is high or low when it should not be, in the same cycle the state settles. A routing error shows as the wrong line rising. The bench therefore compares every port with a behavioural model on every cycle, so a fault is seen no later than the cycle after the edge that caused it.

// File: rtl/icpu_pkg.sv
package icpu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'b00,
    ST_PEND    = 2'b01,
    ST_ACT     = 2'b10,
    ST_ACTPEND = 2'b11
  } int_st_e;
endpackage

// File: rtl/icpu_state_cell.sv
module icpu_state_cell
  import icpu_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    set_hit,
  input  logic    ack_hit,
  input  logic    eoi_hit,
  output int_st_e state
);
  int_st_e state_q, state_d, after_close;

  // acknowledge / end-of-interrupt first, then the new request
  always_comb begin
    after_close = state_q;
    if (ack_hit && state_q == ST_PEND) after_close = ST_ACT;
    if (eoi_hit) begin
      if (state_q == ST_ACT)     after_close = ST_IDLE;
      if (state_q == ST_ACTPEND) after_close = ST_PEND;
    end
    state_d = after_close;
    if (set_hit) begin
      if (after_close == ST_IDLE) state_d = ST_PEND;
      if (after_close == ST_ACT)  state_d = ST_ACTPEND;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

  p_set_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hit && state_q == ST_IDLE) |=> state_q == ST_PEND);
  p_ack_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && state_q == ST_PEND && !set_hit) |=> state_q == ST_ACT);
  p_eoi_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_hit && state_q == ST_ACT && !set_hit) |=> state_q == ST_IDLE);
  p_ack_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && set_hit && state_q == ST_PEND) |=> state_q == ST_ACTPEND);
  p_quiet_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_hit && !ack_hit && !eoi_hit) |=> $stable(state_q));
endmodule

// File: rtl/icpu_arbiter.sv
module icpu_arbiter
  import icpu_pkg::*;
#(
  parameter int NUM_INT = 8,
  parameter int PRIO_W  = 4,
  localparam int IDX_W  = $clog2(NUM_INT)
)(
  input  int_st_e                   st [NUM_INT],
  input  logic [NUM_INT*PRIO_W-1:0] cfg_prio,
  output logic                      best_vld,
  output logic [IDX_W-1:0]          best_id,
  output logic [PRIO_W-1:0]         best_prio,
  output logic                      run_vld,
  output logic [PRIO_W-1:0]         run_prio
);
  // strict compare while scanning upward keeps the lowest ID on ties
  always_comb begin
    best_vld  = 1'b0;
    best_id   = '0;
    best_prio = '1;
    run_vld   = 1'b0;
    run_prio  = '1;
    for (int i = 0; i < NUM_INT; i++) begin
      if (st[i] == ST_PEND && (!best_vld || cfg_prio[i*PRIO_W +: PRIO_W] < best_prio)) begin
        best_vld  = 1'b1;
        best_id   = IDX_W'(i);
        best_prio = cfg_prio[i*PRIO_W +: PRIO_W];
      end
      if ((st[i] == ST_ACT || st[i] == ST_ACTPEND) &&
          (!run_vld || cfg_prio[i*PRIO_W +: PRIO_W] < run_prio)) begin
        run_vld  = 1'b1;
        run_prio = cfg_prio[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irq_cpu_iface.sv
module irq_cpu_iface
  import icpu_pkg::*;
#(
  parameter int NUM_INT = 8,
  parameter int PRIO_W  = 4,
  parameter int ID_W    = 10,
  localparam int IDX_W  = $clog2(NUM_INT),
  localparam logic [ID_W-1:0] SPUR_ID = ID_W'((1 << ID_W) - 1)
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      set_vld,
  input  logic [ID_W-1:0]           set_id,
  input  logic [NUM_INT*PRIO_W-1:0] cfg_prio,
  input  logic [NUM_INT-1:0]        cfg_grp,
  input  logic                      grp0_fiq,
  input  logic [PRIO_W-1:0]         prio_mask,
  input  logic                      ack_rd,
  output logic                      ack_vld,
  output logic [ID_W-1:0]           ack_id,
  input  logic                      eoi_vld,
  input  logic [ID_W-1:0]           eoi_id,
  output logic                      irq_o,
  output logic                      fiq_o,
  output logic [2*NUM_INT-1:0]      int_state
);
  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  int_st_e            st [NUM_INT];
  logic               best_vld, run_vld, elig, sel_grp, route_fiq;
  logic [IDX_W-1:0]   best_id;
  logic [PRIO_W-1:0]  best_prio, run_prio;

  icpu_arbiter #(.NUM_INT(NUM_INT), .PRIO_W(PRIO_W)) u_arb (
    .st(st), .cfg_prio(cfg_prio),
    .best_vld(best_vld), .best_id(best_id), .best_prio(best_prio),
    .run_vld(run_vld), .run_prio(run_prio)
  );

  assign elig      = best_vld && (best_prio < prio_mask) && (!run_vld || best_prio < run_prio);
  assign sel_grp   = cfg_grp[best_id];
  assign route_fiq = !sel_grp && grp0_fiq;
  assign fiq_o     = elig && route_fiq;
  assign irq_o     = elig && !route_fiq;

  for (genvar g = 0; g < NUM_INT; g++) begin : g_cell
    logic set_hit, ack_hit, eoi_hit;
    assign set_hit = set_vld && (set_id == ID_W'(g));
    assign ack_hit = ack_rd && elig && (best_id == IDX_W'(g));
    assign eoi_hit = eoi_vld && (eoi_id == ID_W'(g));
    icpu_state_cell u_cell (
      .clk(clk), .rst_n(rst_q),
      .set_hit(set_hit), .ack_hit(ack_hit), .eoi_hit(eoi_hit),
      .state(st[g])
    );
    assign int_state[2*g +: 2] = st[g];
  end

  logic            ack_vld_d;
  logic [ID_W-1:0] ack_id_d;

  always_comb begin
    ack_vld_d = ack_rd;
    ack_id_d  = ack_id;
    if (ack_rd) ack_id_d = elig ? ID_W'(best_id) : SPUR_ID;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ack_vld <= 1'b0;
      ack_id  <= SPUR_ID;
    end else begin
      ack_vld <= ack_vld_d;
      ack_id  <= ack_id_d;
    end
  end

  p_lines_excl_r8: assert property (@(posedge clk) disable iff (!rst_q)
    !(irq_o && fiq_o));
  p_ack_valid_r3: assert property (@(posedge clk) disable iff (!rst_q)
    ack_rd |=> ack_vld);
  p_spurious_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (ack_rd && !irq_o && !fiq_o) |=> ack_id == SPUR_ID);
  p_mask_gate_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (irq_o || fiq_o) |-> best_prio < prio_mask);
  p_grp1_irq_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (best_vld && sel_grp) |-> !fiq_o);
endmodule

// File: tb/irq_cpu_iface_test.sv
module irq_cpu_iface_test;
  localparam int N = 8, PW = 4, IW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic set_vld = 0, ack_rd = 0, eoi_vld = 0, grp0_fiq = 1;
  logic [IW-1:0] set_id = '0, eoi_id = '0;
  logic [N*PW-1:0] cfg_prio;
  logic [N-1:0] cfg_grp;
  logic [PW-1:0] prio_mask = 4'd15;
  logic ack_vld, irq_o, fiq_o;
  logic [IW-1:0] ack_id;
  logic [2*N-1:0] int_state;

  int checks = 0, errors = 0, cycles = 0;
  int m_st [N];
  int pr [N] = '{5, 3, 3, 8, 1, 12, 7, 15};
  int gr [N] = '{0, 1, 0, 1, 0, 1, 0, 1};
  bit exp_vld = 0;
  int exp_id = 1023;

  always #2 clk = ~clk;

  initial for (int i = 0; i < N; i++) begin
    cfg_prio[i*PW +: PW] = PW'(pr[i]);
    cfg_grp[i] = gr[i][0];
  end

  irq_cpu_iface #(.NUM_INT(N), .PRIO_W(PW), .ID_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .set_vld(set_vld), .set_id(set_id),
    .cfg_prio(cfg_prio), .cfg_grp(cfg_grp), .grp0_fiq(grp0_fiq),
    .prio_mask(prio_mask), .ack_rd(ack_rd), .ack_vld(ack_vld),
    .ack_id(ack_id), .eoi_vld(eoi_vld), .eoi_id(eoi_id),
    .irq_o(irq_o), .fiq_o(fiq_o), .int_state(int_state)
  );

  function automatic int pick();
    int b = -1, run = 99;
    for (int i = 0; i < N; i++) begin
      if (m_st[i] == 1 && (b < 0 || pr[i] < pr[b])) b = i;
      if (m_st[i] >= 2 && pr[i] < run) run = pr[i];
    end
    if (b >= 0 && pr[b] < int'(prio_mask) && pr[b] < run) return b;
    return -1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model: eoi and ack on the old state, then set
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_st[i] = 0;
      exp_vld = 0;
      exp_id = 1023;
    end else begin
      int s;
      s = pick();
      if (eoi_vld && eoi_id < N) begin
        if (m_st[eoi_id] == 2) m_st[eoi_id] = 0;
        else if (m_st[eoi_id] == 3) m_st[eoi_id] = 1;
      end
      exp_vld = ack_rd;
      if (ack_rd) begin
        exp_id = (s >= 0) ? s : 1023;
        if (s >= 0) m_st[s] = 2;
      end
      if (set_vld && set_id < N) begin
        if (m_st[set_id] == 0) m_st[set_id] = 1;
        else if (m_st[set_id] == 2) m_st[set_id] = 3;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n && cycles > 4) begin
      int s;
      bit ef, ei;
      s = pick();
      ef = (s >= 0) && gr[s] == 0 && grp0_fiq;
      ei = (s >= 0) && !ef;
      chk("R8 fiq_o (R7 gate)", fiq_o, ef);
      chk("R8 irq_o (R6 select)", irq_o, ei);
      for (int i = 0; i < N; i++)
        chk("R2/R5 int_state", int_state[2*i +: 2], m_st[i]);
      chk("R3 ack_vld", ack_vld, exp_vld);
      if (exp_vld) chk("R3/R4 ack_id", ack_id, exp_id);
    end
  end

  task automatic cyc(bit s, int sid, bit a, bit e, int eid);
    @(negedge clk); #1;
    set_vld = s; set_id = IW'(sid); ack_rd = a; eoi_vld = e; eoi_id = IW'(eid);
    @(negedge clk); #1;
    set_vld = 0; ack_rd = 0; eoi_vld = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset state", int_state, 0);
    chk("R1 reset lines", {irq_o, fiq_o, ack_vld}, 0);
    cyc(0, 0, 1, 0, 0);            // nothing pending
    chk("R4 spurious id", ack_id, 1023);
    cyc(1, 3, 0, 0, 0);            // group 1 -> irq
    cyc(1, 0, 0, 0, 0);            // group 0, prio 5 -> fiq
    chk("R8 fiq for group 0", fiq_o, 1);
    cyc(0, 0, 1, 0, 0);
    chk("R3 ack returns 0", ack_id, 0);
    chk("R7 running blocks id3", irq_o, 0);
    cyc(1, 4, 0, 0, 0);            // prio 1 preempts
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 4);
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 1, 0, 0);            // takes id3
    cyc(0, 0, 0, 1, 3);
    cyc(1, 2, 0, 0, 0);
    cyc(1, 1, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    chk("R6 tie lowest id", ack_id, 1);
    cyc(1, 1, 0, 0, 0);            // active -> active-and-pending
    chk("R2 active-pending", int_state[3:2], 3);
    cyc(0, 0, 0, 1, 1);            // -> pending
    chk("R5 back to pending", int_state[3:2], 1);
    cyc(0, 0, 0, 1, 5);            // eoi on inactive: ignored
    prio_mask = 4'd3;
    cyc(0, 0, 1, 0, 0);
    chk("R7 mask blocks", ack_id, 1023);
    prio_mask = 4'd15;
    grp0_fiq = 1'b0;
    cyc(0, 0, 1, 0, 0);            // takes id1 (prio 3)
    cyc(0, 0, 1, 0, 0);            // id2 blocked by equal running prio
    cyc(0, 0, 0, 1, 1);
    chk("R8 group 0 on irq", irq_o, 1);
    cyc(1, 2, 1, 0, 0);            // ack + set same id
    chk("R9 ack then set", int_state[5:4], 3);
    cyc(0, 0, 0, 1, 2);
    cyc(0, 0, 1, 0, 0);
    cyc(1, 2, 0, 1, 2);            // eoi + set on active
    chk("R9 eoi then set", int_state[5:4], 1);
    grp0_fiq = 1'b1;
    cyc(1, 7, 0, 0, 0);            // prio 15 never passes mask 15
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 2);
    cyc(0, 0, 1, 0, 0);
    chk("R7 prio 15 masked", ack_id, 1023);
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule